// File: doc/BRIEF.md
# UART Bit-Timing Generator with Cycle Stuffing

This block derives the bit timing of a serial link from a fast reference clock, typically 24 MHz or 48 MHz, for bit rates from 38400 bps up to 6 Mbps. It produces two single-cycle strobes per bit. One marks the sampling point at the end of the first half of the bit. The other marks the end of the bit. A transmitter and a receiver can share both strobes. A bit index and an end-of-frame strobe tell the shift logic where it is within a character. Because the two ends of a link must together stay within about ±2% of each other's rate, the bit period can be trimmed finely. Extra reference-clock cycles can be stuffed into each half of the bit, on top of the coarse divisor.

Software programs a divisor byte and an adjustment byte through two write strobes, and may do so while the link is running. Programmed values are held in shadow form and only become active at a character boundary: either the end of the last bit of a frame, or a receive start pulse that realigns the counter to a detected start edge. After reset the divisor holds 13 and the adjustment holds zero. With a 24 MHz clock this gives about 115200 bps.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset, the divisor register holds DEF_DIV (13), the adjustment register holds DEF_ADJ (0), the bit index is 0, and counting starts at the first cycle out of reset.
- R2: In normal mode, with effective divisor D, the bit lasts 16·D + S1 + S2 reference cycles. The sample strobe falls on cycle 8·D + S1 of the bit and the end-of-bit strobe on its last cycle (cycles counted from 1).
- R3: The adjustment byte's bits [7:4] give S1, the cycles stuffed into the first half. Its bits [3:0] give S2, the cycles stuffed into the second half. A nibble value above 8 counts as 8.
- R4: A divisor value of 0xFF selects high-rate mode. In that mode the first half lasts 1 + S1 cycles and the second half lasts 1 + S2 cycles.
- R5: A divisor value of 0 acts as a divisor of 1, so no half is ever empty.
- R6: A write to either register changes the timing only after the next character boundary. A character boundary is the end-of-frame strobe or a receive start pulse. The value loaded there is the one held in the register during that boundary cycle.
- R7: One cycle after a receive start pulse, the bit index is 0 and the counter is at the first cycle of the first half.
- R8: The bit index advances by one after each end-of-bit strobe and wraps from FRAME_BITS-1 to 0. The end-of-frame strobe is high exactly with the end-of-bit strobe of bit FRAME_BITS-1.
- R9: The sample strobe and the end-of-bit strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_div | input | 1 | Write wdata into the divisor register |
| wr_adj | input | 1 | Write wdata into the adjustment register |
| wdata | input | 8 | Register write data |
| rx_start | input | 1 | Detected start edge: restart the bit counter and load the configuration |
| sample_stb | output | 1 | Mid-bit sampling strobe |
| bit_end_stb | output | 1 | End-of-bit strobe |
| frame_end_stb | output | 1 | End-of-bit strobe of the last bit of a frame |
| bit_index | output | IDX_W | Position of the current bit within the frame |

## Verification
All three strobes and the bit index are decoded from registered state, so they respond in the cycle after the edge that changes that state. A receive start pulse, or a boundary strobe, sampled at one edge shows up at the outputs from the next cycle onward. A register write reaches the timing only through the boundary that follows it. The bench drives inputs and compares outputs on the falling edge. Each cycle it first compares the current outputs against its own model's prediction. It then applies the stimulus for the coming edge and advances the model by exactly one cycle, so every latency above is checked at the cycle where it is due.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;

    localparam int DIV_W     = 8;
    localparam int NIB_W     = 4;
    localparam int STUFF_MAX = 8;
    localparam int LEN_W     = $clog2(8 * (2 ** DIV_W) + STUFF_MAX + 1);

    localparam logic [DIV_W-1:0] FAST_CODE = '1;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    typedef struct packed {
        logic             fast;
        logic [LEN_W-1:0] len_first;
        logic [LEN_W-1:0] len_second;
    } bt_cfg_t;

    function automatic logic [NIB_W-1:0] clamp_stuff(input logic [NIB_W-1:0] nib);
        return (nib > NIB_W'(STUFF_MAX)) ? NIB_W'(STUFF_MAX) : nib;
    endfunction

    function automatic bt_cfg_t decode_cfg(input logic [DIV_W-1:0] div,
                                           input logic [2*NIB_W-1:0] adj);
        bt_cfg_t          c;
        logic [LEN_W-1:0] eff_div;
        logic [LEN_W-1:0] base;
        logic [LEN_W-1:0] s_hi;
        logic [LEN_W-1:0] s_lo;
        eff_div = (div == '0) ? LEN_W'(1) : LEN_W'(div);
        s_hi    = LEN_W'(clamp_stuff(adj[2*NIB_W-1:NIB_W]));
        s_lo    = LEN_W'(clamp_stuff(adj[NIB_W-1:0]));
        c.fast  = (div == FAST_CODE);
        base    = c.fast ? LEN_W'(1) : (eff_div << 3);
        c.len_first  = base + s_hi;
        c.len_second = base + s_lo;
        return c;
    endfunction

endpackage

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
    import uart_bt_pkg::*;
#(
    parameter int DEF_DIV = 13,
    parameter int DEF_ADJ = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_div,
    input  logic                 wr_adj,
    input  logic [DIV_W-1:0]     wdata,
    input  logic                 reload,
    output bt_cfg_t              act_cfg
);

    localparam logic [DIV_W-1:0]   RST_DIV = DIV_W'(DEF_DIV);
    localparam logic [2*NIB_W-1:0] RST_ADJ = (2*NIB_W)'(DEF_ADJ);

    logic [DIV_W-1:0]   prog_div;
    logic [2*NIB_W-1:0] prog_adj;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_div <= RST_DIV;
            prog_adj <= RST_ADJ;
        end else begin
            if (wr_div) prog_div <= wdata;
            if (wr_adj) prog_adj <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= decode_cfg(RST_DIV, RST_ADJ);
        end else if (reload) begin
            act_cfg <= decode_cfg(prog_div, prog_adj);
        end
    end

endmodule

// File: rtl/bt_half_counter.sv
module bt_half_counter
    import uart_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  bt_cfg_t act_cfg,
    output logic    sample_stb,
    output logic    bit_end_stb
);

    half_e            half_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cur_len;
    logic             last;

    always_comb begin
        cur_len = (half_q == HALF_FIRST) ? act_cfg.len_first : act_cfg.len_second;
        last    = (cnt_q == cur_len - LEN_W'(1));
    end

    assign sample_stb  = last && (half_q == HALF_FIRST);
    assign bit_end_stb = last && (half_q == HALF_SECOND);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            half_q <= HALF_FIRST;
            cnt_q  <= '0;
        end else if (last) begin
            half_q <= (half_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

endmodule

// File: rtl/bt_bit_index.sv
module bt_bit_index #(
    parameter int FRAME_BITS = 10,
    localparam int IDX_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             bit_end,
    output logic [IDX_W-1:0] idx,
    output logic             frame_end
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    assign frame_end = bit_end && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx <= '0;
        end else if (frame_end) begin
            idx <= '0;
        end else if (bit_end) begin
            idx <= idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer
    import uart_bt_pkg::*;
#(
    parameter int FRAME_BITS = 10,
    parameter int DEF_DIV    = 13,
    parameter int DEF_ADJ    = 0,
    localparam int IDX_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_div,
    input  logic             wr_adj,
    input  logic [7:0]       wdata,
    input  logic             rx_start,
    output logic             sample_stb,
    output logic             bit_end_stb,
    output logic             frame_end_stb,
    output logic [IDX_W-1:0] bit_index
);

    bt_cfg_t act_cfg;
    logic    reload;

    // Boundary: end of the last bit, or a realignment from the receiver.
    assign reload = rx_start || frame_end_stb;

    bt_cfg_regs #(
        .DEF_DIV (DEF_DIV),
        .DEF_ADJ (DEF_ADJ)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_div  (wr_div),
        .wr_adj  (wr_adj),
        .wdata   (wdata),
        .reload  (reload),
        .act_cfg (act_cfg)
    );

    bt_half_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .restart     (rx_start),
        .act_cfg     (act_cfg),
        .sample_stb  (sample_stb),
        .bit_end_stb (bit_end_stb)
    );

    bt_bit_index #(
        .FRAME_BITS (FRAME_BITS)
    ) u_idx (
        .clk       (clk),
        .rst       (rst),
        .restart   (rx_start),
        .bit_end   (bit_end_stb),
        .idx       (bit_index),
        .frame_end (frame_end_stb)
    );

endmodule

// File: rtl/bt_timing_chk.sv
module bt_timing_chk
    import uart_bt_pkg::*;
#(
    parameter int FRAME_BITS = 10,
    localparam int IDX_W = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_start,
    input logic             sample_stb,
    input logic             bit_end_stb,
    input logic             frame_end_stb,
    input logic [IDX_W-1:0] bit_index,
    input bt_cfg_t          act_cfg
);

    // R9
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && bit_end_stb));

    // R8
    frame_end_last_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_stb |-> (bit_end_stb && bit_index == IDX_W'(FRAME_BITS - 1)));

    // R8
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_end_stb && !rx_start && bit_index != IDX_W'(FRAME_BITS - 1))
            |=> (bit_index == $past(bit_index) + IDX_W'(1)));

    // R7
    rx_restart_chk: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> (bit_index == '0 && !bit_end_stb));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_start || frame_end_stb) |=> $stable(act_cfg));

    // R5
    nonempty_half_chk: assert property (@(posedge clk) disable iff (rst)
        (act_cfg.len_first != '0) && (act_cfg.len_second != '0));

endmodule

bind uart_bit_timer bt_timing_chk #(
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_start      (rx_start),
    .sample_stb    (sample_stb),
    .bit_end_stb   (bit_end_stb),
    .frame_end_stb (frame_end_stb),
    .bit_index     (bit_index),
    .act_cfg       (act_cfg)
);

// File: tb/tb_uart_bit_timer.sv
module tb_uart_bit_timer;

    localparam int FB    = 10;
    localparam int IDX_W = $clog2(FB);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_div = 1'b0;
    logic             wr_adj = 1'b0;
    logic [7:0]       wdata = 8'h00;
    logic             rx_start = 1'b0;
    logic             sample_stb;
    logic             bit_end_stb;
    logic             frame_end_stb;
    logic [IDX_W-1:0] bit_index;

    always #5 clk = ~clk;

    uart_bit_timer #(.FRAME_BITS(FB), .DEF_DIV(13), .DEF_ADJ(0)) dut (
        .clk(clk), .rst(rst), .wr_div(wr_div), .wr_adj(wr_adj), .wdata(wdata),
        .rx_start(rx_start), .sample_stb(sample_stb), .bit_end_stb(bit_end_stb),
        .frame_end_stb(frame_end_stb), .bit_index(bit_index)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    bit    started = 0;
    string req = "R1";

    // Reference model: programmed bytes, active half lengths, cycle within bit.
    int m_div, m_adj, a_l1, a_l2, m_pos, m_idx;

    function automatic int stuff_of(int nib);
        return (nib > 8) ? 8 : nib;
    endfunction

    function automatic int half_len(int div, int nib);
        int d;
        if (div == 255) return 1 + stuff_of(nib);
        d = (div == 0) ? 1 : div;
        return 8 * d + stuff_of(nib);
    endfunction

    task automatic model_load();
        a_l1 = half_len(m_div, (m_adj >> 4) & 15);
        a_l2 = half_len(m_div, m_adj & 15);
    endtask

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(bit rs, bit wd, bit wa, logic [7:0] d, bit rx);
        int  e_samp, e_bend, e_fend;
        bit  boundary;
        @(negedge clk);
        if (started) begin
            e_samp = (m_pos == a_l1 - 1);
            e_bend = (m_pos == a_l1 + a_l2 - 1);
            e_fend = e_bend && (m_idx == FB - 1);
            check("sample_stb", int'(sample_stb), e_samp);
            check("bit_end_stb", int'(bit_end_stb), e_bend);
            check("frame_end_stb", int'(frame_end_stb), e_fend);
            check("bit_index", int'(bit_index), m_idx);
            // R9: strobes never coincide
            if (sample_stb && bit_end_stb) begin
                errors++;
                $display("FAIL R9 both strobes: actual=1 expected=0 at %0t", $time);
            end
            checks++;
        end else begin
            e_fend = 0;
            e_bend = 0;
        end
        rst = rs; wr_div = wd; wr_adj = wa; wdata = d; rx_start = rx;
        if (rs) begin
            m_div = 13; m_adj = 0; model_load(); m_pos = 0; m_idx = 0;
        end else begin
            boundary = rx || (e_fend != 0);
            if (rx) begin
                m_pos = 0; m_idx = 0;
            end else if (e_bend != 0) begin
                m_pos = 0; m_idx = (m_idx + 1) % FB;
            end else begin
                m_pos++;
            end
            if (boundary) model_load();
            if (wd) m_div = int'(d);
            if (wa) m_adj = int'(d);
        end
        started = 1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset values and start of counting
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 8'h00, 0);
        req = "R1";
        idle(120);
        // R2: default normal-mode bit period and frame wrap
        req = "R2";
        idle(2200);
        // R6: writes mid-frame wait for the boundary
        req = "R6";
        idle(37);
        cyc(0, 0, 1, 8'h35, 0);
        idle(50);
        cyc(0, 1, 0, 8'h03, 0);
        idle(2300);
        // R3: nibble placement, both halves stuffed
        req = "R3";
        cyc(0, 0, 1, 8'h72, 0);
        idle(1300);
        // R5: divisor zero
        req = "R5";
        cyc(0, 1, 0, 8'h00, 0);
        cyc(0, 0, 1, 8'h00, 0);
        idle(900);
        // R4: high-rate mode
        req = "R4";
        cyc(0, 1, 0, 8'hFF, 0);
        cyc(0, 0, 1, 8'hF8, 0);
        idle(900);
        cyc(0, 0, 1, 8'h00, 0);
        idle(200);
        cyc(0, 0, 1, 8'h30, 0);
        idle(200);
        // R3: clamp of nibbles above eight
        req = "R3";
        cyc(0, 1, 0, 8'h01, 0);
        cyc(0, 0, 1, 8'h9C, 0);
        idle(900);
        // R7: receive start realignment, with a write just before one pulse
        req = "R7";
        for (int k = 0; k < 20; k++) begin
            idle(k * 7 + 3);
            if (k == 10) cyc(0, 1, 0, 8'h02, 0);
            cyc(0, 0, 0, 8'h00, 1);
        end
        cyc(0, 0, 0, 8'h00, 1);
        cyc(0, 0, 0, 8'h00, 1);
        // R8: long run over several frame wraps
        req = "R8";
        idle(1500);
        done = 1;
        summary();
        $finish;
    end

endmodule